// File: doc/BRIEF.md
# In-Order Completion Tracking List

This block keeps a circular record of every instruction that has been renamed but not yet retired, in program order. Decode writes up to four new entries per cycle. Each entry holds the logical destination register and the physical register that was mapped to that logical register before the rename. The entry's position in the list is a 5-bit tag that travels with the instruction. Execution units return that tag when they finish, and the matching entry is marked done. They may also mark it as having raised an exception.

Retirement happens at the head. Each cycle, up to four consecutive done entries leave in order, and the previous physical register of each one is handed to the free list. When the oldest entry is done and carries an exception flag, retirement stops and a rollback walk begins. The walk starts at the youngest entry and moves back toward the faulting one. Each cycle it presents one logical destination and its previous physical register, so that the rename map table can be restored. While the walk runs, a busy signal stays high. When the walk ends, the list is empty and the next allocation reuses the faulting entry's tag.

The storage is split into four lanes, each eight entries deep. Entry index modulo four selects the lane. Any four consecutive entries therefore fall in four different lanes, and each lane needs only one write port and one window read port.

Top module: `inflight_order_list`

## Requirements
- R1: After reset, occupancy is 0, alloc_tag_base is 0, alloc_ready is 1, grad_valid is 0 and rb_busy is 0.
- R2: An alloc_cnt of 1 to 4, presented while alloc_ready is 1, creates that many entries. Lane j (alloc_ldst bits [j*5 +: 5], alloc_old_preg bits [j*6 +: 6]) receives tag alloc_tag_base+j modulo 32. One edge later, alloc_tag_base and occupancy have advanced by the count. An alloc_cnt of 0 or of 5 to 7 creates nothing.
- R3: alloc_ready is 1 exactly when no rollback is running, the head entry is not both done and flagged, and occupancy is at most 28. A request made while it is 0 leaves occupancy and alloc_tag_base unchanged.
- R4: Each of the three completion ports (cpl_tag port p at bits [p*5 +: 5]) marks the entry with that tag done on the next edge. It also sets the entry's exception flag when cpl_exc of that port is 1.
- R5: With head entry at tag h, grad_valid bit i stands for the entry with tag h+i modulo 32. The set bits are contiguous from bit 0, and there are at most four of them. They appear in the cycle after the completing edge. Head and occupancy advance by their number on the following edge.
- R6: For each set grad_valid bit i, grad_old_preg bits [i*6 +: 6] carry the previous physical register written with that entry.
- R7: Graduation stops at the first entry of the four-entry window that is not done. Younger done entries wait until it completes.
- R8: If the head entry is done and flagged, nothing graduates and rb_busy rises on the next edge. For N cycles, where N is the occupancy at that point, rb_ldst and rb_old_preg present the youngest remaining entry, one per cycle, down to and including the faulting entry. The list is then empty, with alloc_tag_base equal to the faulting tag.
- R9: Tags wrap from 31 to 0. Allocation, completion, graduation and rollback all work the same across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_cnt | input | 3 | Number of entries requested this cycle |
| alloc_ldst | input | 20 | Logical destination per allocation lane |
| alloc_old_preg | input | 24 | Previous physical mapping per allocation lane |
| alloc_ready | output | 1 | Four free entries available and no recovery pending |
| alloc_tag_base | output | 5 | Tag given to allocation lane 0 |
| occupancy | output | 6 | Number of live entries |
| cpl_valid | input | 3 | Completion port valid |
| cpl_tag | input | 15 | Completed tag per port |
| cpl_exc | input | 3 | Completion carries an exception |
| grad_valid | output | 4 | Graduating entries, oldest in bit 0 |
| grad_old_preg | output | 24 | Physical registers to release, per graduation lane |
| rb_busy | output | 1 | Rollback walk in progress |
| rb_ldst | output | 5 | Logical register being restored |
| rb_old_preg | output | 6 | Physical register to write back into the map |

## Verification
A completion or allocation presented before a rising edge shows up in state on that edge. Graduation outputs are decoded from the registered done bits, so they are visible during the cycle after the completing edge. The head moves on the edge after that. Rollback output is also decoded from state: it starts one edge after a flagged done entry reaches the head and then steps back one entry per edge. The bench keeps a cycle model that advances once per rising edge, and it compares every output at the falling edge against the model state from that same edge.

// File: rtl/ool_pkg.sv
package ool_pkg;
  localparam int LREG_W = 5;
  localparam int PREG_W = 6;

  typedef struct packed {
    logic [LREG_W-1:0] ldst;
    logic [PREG_W-1:0] opreg;
  } map_t;
endpackage

// File: rtl/ool_lane_bank.sv
// One lane of the list: ROWS entries whose tags share the low lane bits.
module ool_lane_bank
  import ool_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int LANES   = 4,
  parameter int NCPL    = 3,
  parameter int LANE_ID = 0,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int LANE_W = $clog2(LANES),
  localparam int TAG_W  = ROW_W + LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  map_t              wr_map,
  input  logic [NCPL-1:0]   cpl_valid,
  input  logic [NCPL*TAG_W-1:0] cpl_tag,
  input  logic [NCPL-1:0]   cpl_exc,
  input  logic [ROW_W-1:0]  win_row,
  output logic              win_done,
  output logic              win_exc,
  output logic [PREG_W-1:0] win_opreg,
  input  logic [ROW_W-1:0]  rb_row,
  output map_t              rb_map
);

  logic [ROWS-1:0] done_q, done_d;
  logic [ROWS-1:0] exc_q, exc_d;
  map_t            map_q [ROWS];

  always_comb begin
    done_d = done_q;
    exc_d  = exc_q;
    for (int r = 0; r < ROWS; r++) begin
      for (int p = 0; p < NCPL; p++) begin
        if (cpl_valid[p] &&
            (cpl_tag[p*TAG_W +: LANE_W] == LANE_W'(LANE_ID)) &&
            (cpl_tag[p*TAG_W+LANE_W +: ROW_W] == ROW_W'(r))) begin
          done_d[r] = 1'b1;
          exc_d[r]  = exc_d[r] | cpl_exc[p];
        end
      end
      if (wr_en && (wr_row == ROW_W'(r))) begin
        done_d[r] = 1'b0;
        exc_d[r]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      done_q <= done_d;
      exc_q  <= exc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      map_q[wr_row] <= wr_map;
    end
  end

  assign win_done  = done_q[win_row];
  assign win_exc   = exc_q[win_row];
  assign win_opreg = map_q[win_row].opreg;
  assign rb_map    = map_q[rb_row];

endmodule

// File: rtl/ool_grad_scan.sv
// Finds the run of retirable entries at the head of the window.
module ool_grad_scan #(
  parameter int LANES  = 4,
  localparam int NUM_W = $clog2(LANES + 1)
) (
  input  logic             enable,
  input  logic [LANES-1:0] slot_live,
  input  logic [LANES-1:0] slot_done,
  input  logic [LANES-1:0] slot_exc,
  output logic [LANES-1:0] grad_mask,
  output logic [NUM_W-1:0] grad_num,
  output logic             fault_head
);

  logic run_c;

  always_comb begin
    run_c     = enable;
    grad_mask = '0;
    grad_num  = '0;
    for (int i = 0; i < LANES; i++) begin
      if (run_c && slot_live[i] && slot_done[i] && !slot_exc[i]) begin
        grad_mask[i] = 1'b1;
        grad_num     = grad_num + NUM_W'(1);
      end else begin
        run_c = 1'b0;
      end
    end
  end

  assign fault_head = slot_live[0] & slot_done[0] & slot_exc[0];

endmodule

// File: rtl/inflight_order_list.sv
module inflight_order_list
  import ool_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ROWS     = 8,
  parameter int NCPL     = 3,
  localparam int ENTRIES = LANES * ROWS,
  localparam int TAG_W   = $clog2(ENTRIES),
  localparam int LANE_W  = $clog2(LANES),
  localparam int ROW_W   = $clog2(ROWS),
  localparam int CNT_W   = $clog2(ENTRIES + 1),
  localparam int REQ_W   = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [REQ_W-1:0]        alloc_cnt,
  input  logic [LANES*LREG_W-1:0] alloc_ldst,
  input  logic [LANES*PREG_W-1:0] alloc_old_preg,
  output logic                    alloc_ready,
  output logic [TAG_W-1:0]        alloc_tag_base,
  output logic [CNT_W-1:0]        occupancy,
  input  logic [NCPL-1:0]         cpl_valid,
  input  logic [NCPL*TAG_W-1:0]   cpl_tag,
  input  logic [NCPL-1:0]         cpl_exc,
  output logic [LANES-1:0]        grad_valid,
  output logic [LANES*PREG_W-1:0] grad_old_preg,
  output logic                    rb_busy,
  output logic [LREG_W-1:0]       rb_ldst,
  output logic [PREG_W-1:0]       rb_old_preg
);

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             rb_q, rb_d;
  logic             state_en;

  logic [LANES-1:0]  lane_done, lane_exc;
  logic [PREG_W-1:0] lane_win_opreg [LANES];
  map_t              lane_rb_map [LANES];

  logic [LANES-1:0]  slot_live, slot_done, slot_exc;
  logic [PREG_W-1:0] slot_opreg [LANES];

  logic [LANES-1:0]  grad_mask;
  logic [REQ_W-1:0]  grad_num;
  logic              fault_head;
  logic              alloc_fire;
  logic [REQ_W-1:0]  acc_num;
  logic [TAG_W-1:0]  rb_idx;
  map_t              rb_sel;

  assign rb_idx = tail_q - TAG_W'(1);

  // Storage lanes: entry e lives in lane e mod LANES, row e / LANES.
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [LANE_W-1:0] win_slot, wr_slot;
    logic [TAG_W-1:0]  win_idx, wr_idx;
    logic              wr_en;
    map_t              wr_map;

    assign win_slot = LANE_W'(L) - head_q[LANE_W-1:0];
    assign win_idx  = head_q + TAG_W'(win_slot);
    assign wr_slot  = LANE_W'(L) - tail_q[LANE_W-1:0];
    assign wr_idx   = tail_q + TAG_W'(wr_slot);
    assign wr_en    = alloc_fire && (REQ_W'(wr_slot) < alloc_cnt);
    assign wr_map.ldst  = alloc_ldst[wr_slot*LREG_W +: LREG_W];
    assign wr_map.opreg = alloc_old_preg[wr_slot*PREG_W +: PREG_W];

    ool_lane_bank #(
      .ROWS    (ROWS),
      .LANES   (LANES),
      .NCPL    (NCPL),
      .LANE_ID (L)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_row    (wr_idx[TAG_W-1:LANE_W]),
      .wr_map    (wr_map),
      .cpl_valid (cpl_valid),
      .cpl_tag   (cpl_tag),
      .cpl_exc   (cpl_exc),
      .win_row   (win_idx[TAG_W-1:LANE_W]),
      .win_done  (lane_done[L]),
      .win_exc   (lane_exc[L]),
      .win_opreg (lane_win_opreg[L]),
      .rb_row    (rb_idx[TAG_W-1:LANE_W]),
      .rb_map    (lane_rb_map[L])
    );
  end

  // Window slots in age order: slot i is entry head+i.
  for (genvar i = 0; i < LANES; i++) begin : g_slot
    logic [LANE_W-1:0] sl;
    assign sl            = head_q[LANE_W-1:0] + LANE_W'(i);
    assign slot_live[i]  = CNT_W'(i) < occ_q;
    assign slot_done[i]  = lane_done[sl];
    assign slot_exc[i]   = lane_exc[sl];
    assign slot_opreg[i] = lane_win_opreg[sl];
    assign grad_old_preg[i*PREG_W +: PREG_W] = slot_opreg[i];
  end

  ool_grad_scan #(
    .LANES (LANES)
  ) u_scan (
    .enable     (!rb_q),
    .slot_live  (slot_live),
    .slot_done  (slot_done),
    .slot_exc   (slot_exc),
    .grad_mask  (grad_mask),
    .grad_num   (grad_num),
    .fault_head (fault_head)
  );

  assign alloc_ready = !rb_q && !fault_head &&
                       (occ_q <= CNT_W'(ENTRIES - LANES));
  assign alloc_fire  = alloc_ready && (alloc_cnt != '0) &&
                       (alloc_cnt <= REQ_W'(LANES));
  assign acc_num     = alloc_fire ? alloc_cnt : '0;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    occ_d  = occ_q;
    rb_d   = rb_q;
    if (rb_q) begin
      tail_d = tail_q - TAG_W'(1);
      occ_d  = occ_q - CNT_W'(1);
      rb_d   = (occ_q != CNT_W'(1));
    end else if (fault_head) begin
      rb_d = 1'b1;
    end else begin
      head_d = head_q + TAG_W'(grad_num);
      occ_d  = occ_q - CNT_W'(grad_num);
    end
    tail_d = tail_d + TAG_W'(acc_num);
    occ_d  = occ_d + CNT_W'(acc_num);
  end

  assign state_en = rb_q | fault_head | (grad_num != '0) | alloc_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      rb_q   <= 1'b0;
    end else if (state_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
      rb_q   <= rb_d;
    end
  end

  assign rb_sel         = lane_rb_map[rb_idx[LANE_W-1:0]];
  assign rb_ldst        = rb_sel.ldst;
  assign rb_old_preg    = rb_sel.opreg;
  assign rb_busy        = rb_q;
  assign grad_valid     = grad_mask;
  assign occupancy      = occ_q;
  assign alloc_tag_base = tail_q;

endmodule

// File: rtl/ool_list_chk.sv
module ool_list_chk #(
  parameter int LANES    = 4,
  parameter int ROWS     = 8,
  localparam int ENTRIES = LANES * ROWS,
  localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_ready,
  input logic             rb_busy,
  input logic [CNT_W-1:0] occupancy,
  input logic [LANES-1:0] grad_valid
);

  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(ENTRIES));

  // R3
  ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ready |-> occupancy <= CNT_W'(ENTRIES - LANES));

  // R3
  blocked_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_ready |=> occupancy <= $past(occupancy));

  // R5
  grad_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grad_valid & (grad_valid + LANES'(1))) == '0);

  // R8
  rb_no_grad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_busy |-> grad_valid == '0);

  // R8
  rb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_busy |=> occupancy == CNT_W'($past(occupancy) - 1'b1));

  // R8
  rb_empty_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_busy) |-> occupancy == '0);

endmodule

bind inflight_order_list ool_list_chk #(
  .LANES (LANES),
  .ROWS  (ROWS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_ready (alloc_ready),
  .rb_busy     (rb_busy),
  .occupancy   (occupancy),
  .grad_valid  (grad_valid)
);

// File: tb/inflight_order_list_tb.sv
module inflight_order_list_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int ROWS  = 8;
  localparam int NCPL  = 3;
  localparam int ENT   = LANES * ROWS;

  logic        clk;
  logic        rst_n;
  logic [2:0]  alloc_cnt;
  logic [19:0] alloc_ldst;
  logic [23:0] alloc_old_preg;
  logic        alloc_ready;
  logic [4:0]  alloc_tag_base;
  logic [5:0]  occupancy;
  logic [2:0]  cpl_valid;
  logic [14:0] cpl_tag;
  logic [2:0]  cpl_exc;
  logic [3:0]  grad_valid;
  logic [23:0] grad_old_preg;
  logic        rb_busy;
  logic [4:0]  rb_ldst;
  logic [5:0]  rb_old_preg;

  inflight_order_list #(.LANES(LANES), .ROWS(ROWS), .NCPL(NCPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_ldst(alloc_ldst),
    .alloc_old_preg(alloc_old_preg), .alloc_ready(alloc_ready),
    .alloc_tag_base(alloc_tag_base), .occupancy(occupancy),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_exc(cpl_exc),
    .grad_valid(grad_valid), .grad_old_preg(grad_old_preg),
    .rb_busy(rb_busy), .rb_ldst(rb_ldst), .rb_old_preg(rb_old_preg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Cycle model of the list
  int m_hd, m_tl, m_occ, seq;
  bit m_rb;
  bit m_done [ENT];
  bit m_exc  [ENT];
  int m_ld   [ENT];
  int m_op   [ENT];

  function automatic int ld_of(int s); return (s * 7 + 1) % 32; endfunction
  function automatic int op_of(int s); return (s * 13 + 5) % 64; endfunction

  function automatic bit m_fault();
    return (m_occ > 0) && m_done[m_hd] && m_exc[m_hd];
  endfunction

  function automatic bit m_ready();
    return !m_rb && !m_fault() && (m_occ <= ENT - LANES);
  endfunction

  function automatic int m_gradn();
    int n = 0;
    bit run = !m_rb;
    for (int i = 0; i < LANES; i++) begin
      int e = (m_hd + i) % ENT;
      if (run && i < m_occ && m_done[e] && !m_exc[e]) n++;
      else run = 0;
    end
    return n;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: compare outputs, drive inputs, advance model.
  task automatic tick(string req, int cnt, bit [2:0] cv, int t0, int t1, int t2, bit [2:0] ce);
    int k;
    bit rdy;
    int tg [3];
    k   = m_gradn();
    rdy = m_ready();
    chk(req, "occupancy", int'(occupancy), m_occ);
    chk(req, "alloc_tag_base", int'(alloc_tag_base), m_tl);
    chk(req, "alloc_ready", int'(alloc_ready), int'(rdy));
    chk(req, "grad_valid", int'(grad_valid), (1 << k) - 1);
    for (int i = 0; i < k; i++)
      chk(req, "grad_old_preg", int'(grad_old_preg[i*6 +: 6]), m_op[(m_hd + i) % ENT]);
    chk(req, "rb_busy", int'(rb_busy), int'(m_rb));
    if (m_rb) begin
      chk(req, "rb_ldst", int'(rb_ldst), m_ld[(m_tl + ENT - 1) % ENT]);
      chk(req, "rb_old_preg", int'(rb_old_preg), m_op[(m_tl + ENT - 1) % ENT]);
    end
    // drive
    alloc_cnt = 3'(cnt);
    for (int j = 0; j < LANES; j++) begin
      alloc_ldst[j*5 +: 5]     = 5'(ld_of(seq + j));
      alloc_old_preg[j*6 +: 6] = 6'(op_of(seq + j));
    end
    cpl_valid = cv;
    cpl_exc   = ce;
    cpl_tag   = {5'(t2), 5'(t1), 5'(t0)};
    // model
    tg[0] = t0; tg[1] = t1; tg[2] = t2;
    if (m_rb) begin
      m_tl  = (m_tl + ENT - 1) % ENT;
      m_occ = m_occ - 1;
      if (m_occ == 0) m_rb = 0;
    end else if (m_fault()) begin
      m_rb = 1;
    end else begin
      m_hd  = (m_hd + k) % ENT;
      m_occ = m_occ - k;
    end
    if (rdy && cnt >= 1 && cnt <= LANES) begin
      for (int j = 0; j < cnt; j++) begin
        int e = (m_tl + j) % ENT;
        m_ld[e] = ld_of(seq + j);
        m_op[e] = op_of(seq + j);
        m_done[e] = 0;
        m_exc[e]  = 0;
      end
      m_tl  = (m_tl + cnt) % ENT;
      m_occ = m_occ + cnt;
      seq   = seq + cnt;
    end
    for (int p = 0; p < NCPL; p++) begin
      if (cv[p]) begin
        m_done[tg[p] % ENT] = 1;
        if (ce[p]) m_exc[tg[p] % ENT] = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(string req);
    tick(req, 0, 3'b000, 0, 0, 0, 3'b000);
  endtask

  // Complete the oldest three live entries each cycle until empty.
  task automatic drain(string req);
    for (int g = 0; g < 100 && (m_occ > 0 || m_rb); g++) begin
      bit [2:0] v;
      v[0] = !m_rb && (m_occ > 0);
      v[1] = !m_rb && (m_occ > 1);
      v[2] = !m_rb && (m_occ > 2);
      tick(req, 0, v, m_hd, (m_hd + 1) % ENT, (m_hd + 2) % ENT, 3'b000);
    end
  endtask

  task automatic wait_rb(string req);
    for (int g = 0; g < 60 && (m_rb || m_fault()); g++) idle(req);
    idle(req);
  endtask

  initial begin
    int fill [12] = '{1, 2, 3, 7, 4, 1, 2, 3, 4, 4, 4, 1};
    rst_n = 1'b0;
    alloc_cnt = '0; alloc_ldst = '0; alloc_old_preg = '0;
    cpl_valid = '0; cpl_tag = '0; cpl_exc = '0;
    m_hd = 0; m_tl = 0; m_occ = 0; m_rb = 0; seq = 0;
    for (int e = 0; e < ENT; e++) begin
      m_done[e] = 0; m_exc[e] = 0; m_ld[e] = 0; m_op[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle("R1");
    idle("R1");

    // R2: allocation counts 1..4, plus an out-of-range count of 7
    foreach (fill[i]) tick("R2", fill[i], 3'b000, 0, 0, 0, 3'b000);
    // R3: occupancy 29, requests ignored while not ready
    tick("R3", 4, 3'b000, 0, 0, 0, 3'b000);
    tick("R3", 4, 3'b000, 0, 0, 0, 3'b000);
    idle("R3");

    // R7: a younger entry done first waits for the head
    tick("R7", 0, 3'b001, 2, 0, 0, 3'b000);
    idle("R7");
    // R4: completing the head releases one entry
    tick("R4", 0, 3'b001, 0, 0, 0, 3'b000);
    idle("R4");
    // R5 / R6: completing tag 1 releases tags 1 and 2 together
    tick("R5", 0, 3'b001, 1, 0, 0, 3'b000);
    idle("R6");

    // R9: out-of-order completions with rolling allocation across the tag wrap
    for (int c = 0; c < 120; c++) begin
      int o0 = (c * 3) % 5;
      int o1 = (c * 3 + 2) % 5;
      int o2 = (c * 3 + 4) % 5;
      bit [2:0] v;
      v[0] = o0 < m_occ; v[1] = o1 < m_occ; v[2] = o2 < m_occ;
      tick("R9", c % 5, v, (m_hd + o0) % ENT, (m_hd + o1) % ENT, (m_hd + o2) % ENT, 3'b000);
    end
    drain("R5");

    // R8: flagged entry behind two clean ones, five younger entries rolled back
    tick("R8", 4, 3'b000, 0, 0, 0, 3'b000);
    tick("R8", 4, 3'b000, 0, 0, 0, 3'b000);
    tick("R8", 0, 3'b111, m_hd, (m_hd + 1) % ENT, (m_hd + 2) % ENT, 3'b100);
    tick("R8", 0, 3'b011, (m_hd + 3) % ENT, (m_hd + 4) % ENT, 0, 3'b000);
    wait_rb("R8");
    // R8: flagged head with all entries done
    tick("R8", 4, 3'b000, 0, 0, 0, 3'b000);
    tick("R8", 0, 3'b111, m_hd, (m_hd + 1) % ENT, (m_hd + 2) % ENT, 3'b001);
    tick("R8", 0, 3'b001, (m_hd + 3) % ENT, 0, 0, 3'b000);
    wait_rb("R8");
    // R8: single flagged entry
    tick("R8", 1, 3'b000, 0, 0, 0, 3'b000);
    tick("R8", 0, 3'b001, m_hd, 0, 0, 3'b001);
    wait_rb("R8");
    // R2: allocation resumes at the faulting tag
    tick("R2", 3, 3'b000, 0, 0, 0, 3'b000);
    drain("R5");
    idle("R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule